// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block runs I2C master transfers one chunk at a time, as software programs them through a small register window. Software sets a control word that holds enable, mode, start and stop requests and the ACK policy. It fills a 32-byte transmit buffer and then writes a byte count. The sequencer then hands the bus operations, one at a time, to a separate bit-level SCL/SDA timing engine. The operations are START, STOP, write byte and read byte with ACK or NACK. Each result is recorded as a pending-interrupt bit.

There are three modes: plain transmit, plain receive, and a register-read mode. The register-read mode writes the device address and up to three register-address bytes, issues a repeated START, re-addresses the device for reading, and then receives. A receive longer than one chunk continues in plain receive mode with no new START. Received bytes are packed little-endian, four to a word, in a 32-byte receive buffer.

Top module: `i2c_xfer_seq`

## Requirements
- R1: After reset the control word, the pending bits, `irq` and `bit_req` are all 0.
- R2: A control write with bit 0 set that raises bit 3 (stored value was 0) requests one START operation (`bit_op`=0). When that operation completes, pending bit 4 is set.
- R3: In mode 0 (control bits 2:1), writing n to the transmit count (word 3) while idle issues n write operations (`bit_op`=2). Byte k is taken from transmit word 16+k/4, bits 8*(k%4)+7:8*(k%4). Each completed write sets pending bit 0, and completing byte n-1 sets pending bit 2.
- R4: In mode 2, writing n to the receive count (word 4) while idle issues n read operations (`bit_op`=3). Received byte k is stored in receive word 32+k/4, bits 8*(k%4)+7:8*(k%4). Each read sets pending bit 1, and the last read sets pending bit 3.
- R5: `bit_nack` is 0 on every read of a chunk except the last one, where it equals control bit 5.
- R6: The first receive chunk in mode 1 after a START runs a fixed sequence. It writes the device-address word (word 1) with bit 0 forced to 0. It then writes register-address byte x (word 2, bits 8x+7:8x) for each x=0..2 whose flag bit 24+x is set, in rising x order. Next come a START, the device address with bit 0 forced to 1, and the reads. Later chunks before the next START issue only reads.
- R7: A slave NACK on any write sets pending bit 6. If control bit 6 is set, the chunk ends at that byte with no finished bit. Otherwise the chunk continues.
- R8: A control write with bit 0 set that raises bit 4 queues a STOP. The STOP (`bit_op`=1) is issued once the operation in progress completes, and it cuts short any running chunk, so that chunk sets no finished bit. Completion of the STOP sets pending bit 5.
- R9: Writing 1 to a pending bit (word 6) clears it. `irq` is high exactly when some pending bit is set and its enable bit (word 5) is set.
- R10: A count write that arrives while any bus operation is outstanding is ignored: no extra operations are issued and the count register keeps its value.
- R11: Counts above 32 are treated as 32. A count of 0 sets the chunk's finished bit at once, with no bus operation.
- R12: Control bits 15:0 read back as written, so the tuning byte 15:8 is kept across mode writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| irq | output | 1 | Interrupt: any enabled pending bit |
| bit_req | output | 1 | Operation request to the bit engine, held until done |
| bit_op | output | 2 | Operation: 0 START, 1 STOP, 2 write byte, 3 read byte |
| bit_wbyte | output | 8 | Byte to write |
| bit_nack | output | 1 | For reads: answer with NACK instead of ACK |
| bit_done | input | 1 | One-cycle completion pulse from the bit engine |
| bit_rbyte | input | 8 | Byte read, valid with `bit_done` |
| bit_ack_n | input | 1 | Slave NACKed the written byte, valid with `bit_done` |

## Verification
Transmit chunks use random buffer contents with random lengths plus a full 32-byte chunk. This shows whether the word and lane selection of each byte is right across all eight words. Receive chunks return random bytes from the modelled bit engine and are run with the last-byte ACK bit both set and clear, which separates correct packing from the chunk-end ACK policy. In the register-read pattern, a gap in the valid flags shows whether invalid address bytes are skipped. That run is followed by a second chunk that must not repeat the prefix. NACK runs are made with and without stop-on-NACK. A STOP forced in mid-chunk, count writes while busy, and counts of 0 and 50 each check a behaviour of their own.

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq #(
  parameter int CHUNK_BYTES = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [5:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        bit_req,
  output logic [1:0]  bit_op,
  output logic [7:0]  bit_wbyte,
  output logic        bit_nack,
  input  logic        bit_done,
  input  logic [7:0]  bit_rbyte,
  input  logic        bit_ack_n
);
  localparam int WORDS = CHUNK_BYTES / 4;
  localparam int WW = $clog2(WORDS);
  localparam int CW = $clog2(CHUNK_BYTES + 1);
  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [5:0] A_CTRL = 6'd0, A_DEV = 6'd1, A_REG = 6'd2, A_TXN = 6'd3,
                         A_RXN = 6'd4, A_IEN = 6'd5, A_IPD = 6'd6;
  localparam logic [1:0] OP_START = 2'd0, OP_STOP = 2'd1, OP_WR = 2'd2, OP_RD = 2'd3;

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_STOP, ST_TX, ST_PRE, ST_RS, ST_RA, ST_RX} st_t;
  st_t st;

  logic [15:0] ctrl;
  logic [7:0]  dev;
  logic [23:0] rega;
  logic [2:0]  regv;
  logic [CW-1:0] txcnt, rxcnt, idx;
  logic [6:0]  ien, ipd, ipd_set;
  logic [31:0] txbuf [WORDS];
  logic [31:0] rxbuf [WORDS];
  logic [1:0]  pi;
  logic        pre_done, start_pend, stop_pend;

  function automatic logic [1:0] pre_next(input logic [1:0] p, input logic [2:0] v);
    case (p)
      2'd0:    pre_next = v[0] ? 2'd1 : v[1] ? 2'd2 : v[2] ? 2'd3 : 2'd0;
      2'd1:    pre_next = v[1] ? 2'd2 : v[2] ? 2'd3 : 2'd0;
      2'd2:    pre_next = v[2] ? 2'd3 : 2'd0;
      default: pre_next = 2'd0;
    endcase
  endfunction

  wire [1:0] mode = ctrl[2:1];
  wire ctl_wr = reg_we && reg_addr == A_CTRL;
  wire start_rise = ctl_wr && reg_wdata[0] && reg_wdata[3] && !ctrl[3];
  wire stop_rise  = ctl_wr && reg_wdata[0] && reg_wdata[4] && !ctrl[4];
  wire can_go = st == ST_IDLE && ctrl[0] && !start_pend && !stop_pend;
  wire tx_go = reg_we && reg_addr == A_TXN && can_go && mode == 2'd0;
  wire rx_go = reg_we && reg_addr == A_RXN && can_go && mode != 2'd0;
  wire [CW-1:0] wcnt = (reg_wdata > 32'(CHUNK_BYTES)) ? CW'(CHUNK_BYTES) : reg_wdata[CW-1:0];
  wire nack_abort = bit_ack_n && ctrl[6];
  wire tx_last = idx == txcnt - ONE;
  wire rx_last = idx == rxcnt - ONE;
  wire [31:0] txw = txbuf[idx[WW+1:2]];

  assign bit_req = st != ST_IDLE;
  assign bit_nack = st == ST_RX && rx_last && ctrl[5];
  assign irq = |(ien & ipd);

  always_comb begin
    case (st)
      ST_STOP:               bit_op = OP_STOP;
      ST_TX, ST_PRE, ST_RA:  bit_op = OP_WR;
      ST_RX:                 bit_op = OP_RD;
      default:               bit_op = OP_START;
    endcase
    case (st)
      ST_TX:   bit_wbyte = txw[{idx[1:0], 3'b000} +: 8];
      ST_PRE:  bit_wbyte = (pi == 2'd0) ? {dev[7:1], 1'b0} : rega[{pi - 2'd1, 3'b000} +: 8];
      ST_RA:   bit_wbyte = {dev[7:1], 1'b1};
      default: bit_wbyte = 8'h00;
    endcase
  end

  always_comb begin
    ipd_set = '0;
    if (bit_done && bit_req) begin
      case (st)
        ST_START: ipd_set[4] = 1'b1;
        ST_STOP:  ipd_set[5] = 1'b1;
        ST_TX: begin
          ipd_set[0] = 1'b1;
          ipd_set[6] = bit_ack_n;
          ipd_set[2] = tx_last && !nack_abort;
        end
        ST_PRE, ST_RA: begin
          ipd_set[0] = 1'b1;
          ipd_set[6] = bit_ack_n;
        end
        ST_RX: begin
          ipd_set[1] = 1'b1;
          ipd_set[3] = rx_last;
        end
        default: ;
      endcase
    end
    if (tx_go && wcnt == '0) ipd_set[2] = 1'b1;
    if (rx_go && wcnt == '0) ipd_set[3] = 1'b1;
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {16'h0, ctrl};
      A_DEV:   reg_rdata = {24'h0, dev};
      A_REG:   reg_rdata = {5'h0, regv, rega};
      A_TXN:   reg_rdata = 32'(txcnt);
      A_RXN:   reg_rdata = 32'(rxcnt);
      A_IEN:   reg_rdata = {25'h0, ien};
      A_IPD:   reg_rdata = {25'h0, ipd};
      default: begin
        reg_rdata = 32'h0;
        if (reg_addr[5:4] == 2'b01 && reg_addr[3:0] < 4'(WORDS)) reg_rdata = txbuf[reg_addr[WW-1:0]];
        if (reg_addr[5:4] == 2'b10 && reg_addr[3:0] < 4'(WORDS)) reg_rdata = rxbuf[reg_addr[WW-1:0]];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      ctrl <= '0; dev <= '0; rega <= '0; regv <= '0;
      txcnt <= '0; rxcnt <= '0; idx <= '0; ien <= '0; ipd <= '0;
      pi <= '0; pre_done <= 1'b0; start_pend <= 1'b0; stop_pend <= 1'b0;
      for (int w = 0; w < WORDS; w++) begin
        txbuf[w] <= '0;
        rxbuf[w] <= '0;
      end
    end else begin
      if (ctl_wr) ctrl <= reg_wdata[15:0];
      if (reg_we && reg_addr == A_DEV) dev <= reg_wdata[7:0];
      if (reg_we && reg_addr == A_REG) begin
        rega <= reg_wdata[23:0];
        regv <= reg_wdata[26:24];
      end
      if (reg_we && reg_addr == A_IEN) ien <= reg_wdata[6:0];
      if (reg_we && reg_addr[5:4] == 2'b01 && reg_addr[3:0] < 4'(WORDS)) txbuf[reg_addr[WW-1:0]] <= reg_wdata;
      ipd <= (ipd & ~((reg_we && reg_addr == A_IPD) ? reg_wdata[6:0] : 7'h0)) | ipd_set;
      if (tx_go) txcnt <= wcnt;
      if (rx_go) rxcnt <= wcnt;

      case (st)
        ST_IDLE: begin
          if (stop_pend) begin
            st <= ST_STOP; stop_pend <= 1'b0;
          end else if (start_pend) begin
            st <= ST_START; start_pend <= 1'b0;
          end else if (tx_go && wcnt != '0) begin
            st <= ST_TX; idx <= '0;
          end else if (rx_go && wcnt != '0) begin
            idx <= '0; pi <= '0;
            st <= (mode == 2'd1 && !pre_done) ? ST_PRE : ST_RX;
          end
        end
        ST_START, ST_STOP: if (bit_done) begin
          st <= ST_IDLE; pre_done <= 1'b0;
        end
        ST_TX: if (bit_done) begin
          if (nack_abort || tx_last || stop_pend) st <= ST_IDLE;
          else idx <= idx + ONE;
        end
        ST_PRE: if (bit_done) begin
          if (nack_abort || stop_pend) st <= ST_IDLE;
          else if (pre_next(pi, regv) != 2'd0) pi <= pre_next(pi, regv);
          else st <= ST_RS;
        end
        ST_RS: if (bit_done) st <= stop_pend ? ST_IDLE : ST_RA;
        ST_RA: if (bit_done) begin
          if (nack_abort || stop_pend) st <= ST_IDLE;
          else begin
            st <= ST_RX; pre_done <= 1'b1;
          end
        end
        ST_RX: if (bit_done) begin
          rxbuf[idx[WW+1:2]][{idx[1:0], 3'b000} +: 8] <= bit_rbyte;
          if (rx_last || stop_pend) st <= ST_IDLE;
          else idx <= idx + ONE;
        end
        default: st <= ST_IDLE;
      endcase

      if (start_rise) start_pend <= 1'b1;
      if (stop_rise) stop_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/i2c_xfer_seq_chk.sv
module i2c_xfer_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bit_req,
  input logic [1:0]  bit_op,
  input logic        bit_done,
  input logic        bit_ack_n,
  input logic        bit_nack,
  input logic [15:0] ctrl,
  input logic [6:0]  ipd
);
  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_req && !bit_done |=> bit_req && $stable(bit_op));
  // R2
  start_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ipd[4]) |-> $past(bit_done && bit_op == 2'd0));
  // R8
  stop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ipd[5]) |-> $past(bit_done && bit_op == 2'd1));
  // R7
  nack_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ipd[6]) |-> $past(bit_done && bit_ack_n && bit_op == 2'd2));
  // R5
  last_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_req && bit_nack |-> bit_op == 2'd3 && ctrl[5]);
endmodule

bind i2c_xfer_seq i2c_xfer_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_req(bit_req), .bit_op(bit_op), .bit_done(bit_done),
  .bit_ack_n(bit_ack_n), .bit_nack(bit_nack), .ctrl(ctrl), .ipd(ipd)
);

// File: tb/tb_i2c_xfer_seq.sv
module tb_i2c_xfer_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic reg_we; logic [5:0] reg_addr; logic [31:0] reg_wdata, reg_rdata;
  logic irq, bit_req, bit_nack, bit_done, bit_ack_n;
  logic [1:0] bit_op; logic [7:0] bit_wbyte, bit_rbyte;

  i2c_xfer_seq dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .bit_req(bit_req), .bit_op(bit_op), .bit_wbyte(bit_wbyte),
    .bit_nack(bit_nack), .bit_done(bit_done), .bit_rbyte(bit_rbyte), .bit_ack_n(bit_ack_n)
  );

  int total = 0, bad = 0;
  logic [1:0] lop [0:255];
  logic [7:0] lbyte [0:255];
  logic lnack [0:255];
  int lcnt = 0, wr_seen = 0, nack_at = -1;
  logic [31:0] tw [0:7];

  initial begin
    bit_done = 1'b0; bit_rbyte = 8'h00; bit_ack_n = 1'b0;
    forever begin
      @(negedge clk);
      if (bit_req) begin
        lop[lcnt] = bit_op; lnack[lcnt] = bit_nack; lbyte[lcnt] = bit_wbyte;
        repeat ($urandom_range(0, 2)) @(negedge clk);
        bit_rbyte = 8'($urandom);
        if (bit_op == 2'd3) lbyte[lcnt] = bit_rbyte;
        bit_ack_n = (bit_op == 2'd2 && wr_seen == nack_at);
        if (bit_op == 2'd2) wr_seen++;
        bit_done = 1'b1;
        lcnt++;
        @(negedge clk);
        bit_done = 1'b0; bit_ack_n = 1'b0;
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic quiet();
    int q = 0;
    while (q < 6) begin
      @(negedge clk);
      q = bit_req ? 0 : q + 1;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clr_log();
    lcnt = 0; wr_seen = 0;
  endtask

  function automatic logic [7:0] txb(int k);
    return tw[k / 4][8 * (k % 4) +: 8];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, expw, mask;
    int n;
    bit ok, lastack;
    reg_we = 1'b0; reg_addr = 6'd0; reg_wdata = 32'h0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(6'd0, v); chk(v == 0, "R1 ctrl", v, 0);
    rd(6'd6, v); chk(v == 0, "R1 pending", v, 0);
    chk(bit_req == 1'b0, "R1 bit_req", 32'(bit_req), 0);
    chk(irq == 1'b0, "R1 irq", 32'(irq), 0);

    wr(6'd0, 32'hA501); rd(6'd0, v); chk(v == 32'hA501, "R12 ctrl readback", v, 32'hA501);

    wr(6'd5, 32'h10); clr_log(); wr(6'd0, 32'hA509); quiet();
    chk(lcnt == 1 && lop[0] == 2'd0, "R2 start op", 32'(lcnt), 1);
    rd(6'd6, v); chk(v[4], "R2 start pending", v, 32'h10);
    chk(irq == 1'b1, "R9 irq high", 32'(irq), 1);
    wr(6'd6, 32'h10); rd(6'd6, v); chk(v == 0, "R9 clear", v, 0);
    chk(irq == 1'b0, "R9 irq low", 32'(irq), 0);
    wr(6'd5, 32'h0);
    wr(6'd0, 32'hA501); rd(6'd0, v); chk(v == 32'hA501, "R12 tuning kept", v, 32'hA501);

    for (int it = 0; it < 4; it++) begin
      for (int w = 0; w < 8; w++) begin
        tw[w] = $urandom;
        wr(6'(16 + w), tw[w]);
      end
      n = (it == 0) ? 32 : $urandom_range(1, 31);
      clr_log(); wr(6'd6, 32'h7F); wr(6'd3, 32'(n)); quiet();
      ok = (lcnt == n);
      for (int k = 0; k < n; k++) ok &= (lop[k] == 2'd2) && (lbyte[k] == txb(k));
      chk(ok, "R3 tx bytes", 32'(lcnt), 32'(n));
      rd(6'd6, v); chk(v[0] && v[2], "R3 tx flags", v, 32'h5);
    end

    clr_log(); wr(6'd3, 32'd10); wr(6'd3, 32'd5); quiet();
    chk(lcnt == 10, "R10 busy write ignored", 32'(lcnt), 10);
    rd(6'd3, v); chk(v == 10, "R10 count kept", v, 10);

    clr_log(); wr(6'd6, 32'h7F); wr(6'd3, 32'd0); quiet();
    chk(lcnt == 0, "R11 zero count no ops", 32'(lcnt), 0);
    rd(6'd6, v); chk(v[2], "R11 zero count finished", v, 32'h4);
    clr_log(); wr(6'd3, 32'd50); quiet();
    chk(lcnt == 32, "R11 clamp ops", 32'(lcnt), 32);
    rd(6'd3, v); chk(v == 32, "R11 clamp count", v, 32);

    wr(6'd0, 32'hA541); clr_log(); nack_at = 2; wr(6'd6, 32'h7F); wr(6'd3, 32'd6); quiet();
    chk(lcnt == 3, "R7 stop on nack", 32'(lcnt), 3);
    rd(6'd6, v); chk(v[6] && !v[2], "R7 nack flags abort", v, 32'h41);
    wr(6'd0, 32'hA501); clr_log(); nack_at = 1; wr(6'd6, 32'h7F); wr(6'd3, 32'd4); quiet();
    chk(lcnt == 4, "R7 nack ignored", 32'(lcnt), 4);
    rd(6'd6, v); chk(v[6] && v[2], "R7 nack flags continue", v, 32'h45);
    nack_at = -1;

    for (int it = 0; it < 3; it++) begin
      lastack = (it != 1);
      wr(6'd0, 32'hA505 | (lastack ? 32'h20 : 32'h0));
      n = (it == 0) ? 32 : $urandom_range(1, 31);
      clr_log(); wr(6'd6, 32'h7F); wr(6'd4, 32'(n)); quiet();
      ok = (lcnt == n);
      for (int k = 0; k < n; k++) ok &= (lop[k] == 2'd3);
      chk(ok, "R4 read ops", 32'(lcnt), 32'(n));
      ok = 1'b1;
      for (int k = 0; k < n; k++) ok &= (lnack[k] == ((k == n - 1) ? lastack : 1'b0));
      chk(ok, "R5 ack policy", 32'(lnack[n-1]), 32'(lastack));
      ok = 1'b1;
      for (int w = 0; w <= (n - 1) / 4; w++) begin
        expw = 0; mask = 0;
        for (int j = 0; j < 4; j++) if (w * 4 + j < n) begin
          expw[8*j +: 8] = lbyte[w*4+j];
          mask[8*j +: 8] = 8'hFF;
        end
        rd(6'(32 + w), v);
        ok &= ((v & mask) == expw);
      end
      chk(ok, "R4 rx packing", v, expw);
      rd(6'd6, v); chk(v[1] && v[3], "R4 rx flags", v, 32'hA);
    end

    wr(6'd1, 32'hA7); wr(6'd2, 32'h0533_2211);
    wr(6'd0, 32'hA523); wr(6'd0, 32'hA52B); quiet(); wr(6'd0, 32'hA523);
    clr_log(); wr(6'd6, 32'h7F); wr(6'd4, 32'd3); quiet();
    ok = (lcnt == 8) && lop[0] == 2'd2 && lbyte[0] == 8'hA6 && lop[1] == 2'd2 && lbyte[1] == 8'h11
         && lop[2] == 2'd2 && lbyte[2] == 8'h33 && lop[3] == 2'd0 && lop[4] == 2'd2 && lbyte[4] == 8'hA7
         && lop[5] == 2'd3 && lop[6] == 2'd3 && lop[7] == 2'd3;
    chk(ok, "R6 register prefix", 32'(lcnt), 8);
    rd(6'd6, v); chk(v[3], "R6 finished", v, 32'h8);
    wr(6'd0, 32'hA525); clr_log(); wr(6'd4, 32'd2); quiet();
    chk(lcnt == 2 && lop[0] == 2'd3 && lop[1] == 2'd3, "R6 continuation reads only", 32'(lcnt), 2);

    clr_log(); wr(6'd6, 32'h7F); wr(6'd4, 32'd20);
    repeat (8) @(negedge clk);
    wr(6'd0, 32'hA535); quiet();
    chk(lcnt > 0 && lcnt < 21 && lop[lcnt-1] == 2'd1, "R8 forced stop last", 32'(lcnt), 0);
    rd(6'd6, v); chk(v[5] && !v[3], "R8 stop flags", v, 32'h20);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule